// File: doc/BRIEF.md
# Legacy Memory Window Access Router

This block sits beside the address path of a processor complex and classifies every access that falls in the legacy first megabyte, plus memory above it up to a programmable DRAM limit. For each access it picks a destination: system DRAM, the graphics pipeline, the PCI master, or a refusal (for PCI-slave accesses that are not permitted). It also reports whether the access may be cached, raises a system-management trap request for I/O accesses to enabled video port ranges, and returns the address after the optional bit-20 mask.

Four 32-bit control words are loaded through a one-cycle write port: a DRAM limit word, a video-area word, and two words of 4-bit window controls for the 16KB windows from C0000h to FFFFFh. An access is presented for one cycle with its address and attributes, and the decision appears on registered outputs on the next clock. Route codes are 0 = DRAM, 1 = graphics, 2 = PCI master, 3 = refused.

Top module: `legacy_window_router`

## Requirements
- R1: After reset all outputs are 0, the DRAM limit is 3FFFFFFFh and every window control field is 0, so a CPU read at C0000h goes to the PCI master (route 2) and a read at 200000h goes to DRAM.
- R2: Each access presented with acc_valid high produces exactly one rsp_valid pulse, with its results, on the following clock; no rsp_valid appears without an access.
- R3: A CPU memory access below A0000h goes to DRAM (route 0) and is cacheable.
- R4: Window n (n = 0..15) covers C0000h + n*4000h for 16KB; its 4-bit field sits at bits 4n+3:4n of register select 2 for n < 8 and at bits 4(n-8)+3:4(n-8) of select 3 otherwise.
- R5: Within a window field bit 0 enables reads and bit 1 enables writes; a CPU access whose enable is set goes to DRAM, otherwise to the PCI master.
- R6: A CPU access to a window reports cacheable equal to field bit 2, independent of the read and write enables, so a write to a cacheable but non-writable window still reports cacheable (the cache is updated).
- R7: A PCI-slave memory access to a window goes to DRAM only when field bit 3 and the matching read or write enable are both set, otherwise it is refused (route 3); PCI-slave accesses are never cacheable.
- R8: Register select 1 holds the controls of A0000h-AFFFFh, B0000h-B7FFFh and B8000h-BFFFFh at bits 3:0, 19:16 and 27:24, with graphics-enable bits 4, 20 and 28; with graphics-enable set the access goes to the graphics pipeline (route 1), not cacheable, otherwise the field applies as in R5 to R7.
- R9: Bits 13, 14 and 15 of select 1 enable a trap request for I/O accesses to 3B0h-3BFh, 3C0h-3CFh and 3D0h-3DFh; every I/O access is routed to the PCI master and is not cacheable.
- R10: With bit 21 of select 1 set, address bit 20 is forced to 0 for every access made outside system-management mode; the decode and rsp_addr use the masked address.
- R11: Register select 0 bits 29:17 set the DRAM limit as {bits 29:17, 17'h1FFFF}; other bits written are ignored. Memory from 100000h to the limit goes to DRAM (cacheable for the CPU); above it a CPU access goes to the PCI master and a PCI-slave access is refused.
- R12: A register write affects accesses from the next cycle on; an access presented in the same cycle as the write is decoded with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_sel | input | 2 | Control word select (0 limit, 1 video, 2 and 3 windows) |
| cfg_wdata | input | 32 | Control word write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_io | input | 1 | 1 = I/O access, 0 = memory |
| acc_pci | input | 1 | Access made by the PCI slave |
| acc_smm | input | 1 | Access made in system-management mode |
| rsp_valid | output | 1 | Decision valid |
| rsp_route | output | 2 | Destination code |
| rsp_cacheable | output | 1 | Access may be cached |
| rsp_smi | output | 1 | Trap request for the I/O access |
| rsp_addr | output | 32 | Address after bit-20 mask |

## Verification
Every decision is due exactly one clock after the cycle the access is driven, and a control word write is due to take effect for the access driven one cycle after the write. The driver pushes the expected route, cacheable flag, trap flag and address into a queue when it drives an access on a falling edge; the monitor samples on the next falling edge, where the registered result is stable, and compares against the head of the queue, flagging any result that appears with an empty queue. The same-cycle write case is driven on one edge with both strobes, so the old and new control values are checked on adjacent results.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int WIN_CNT  = 16;
    localparam int FLD_W    = 4;
    localparam int LIM_LO   = 17;
    localparam int LIM_W    = 13;

    typedef enum logic [1:0] {
        ROUTE_DRAM = 2'd0,
        ROUTE_GFX  = 2'd1,
        ROUTE_PCI  = 2'd2,
        ROUTE_DENY = 2'd3
    } route_e;

    typedef struct packed {
        logic              valid;
        route_e            route;
        logic              cacheable;
        logic              smi;
        logic [ADDR_W-1:0] addr;
    } resp_t;

    typedef struct packed {
        logic [LIM_W-1:0]         lim;
        logic [DATA_W-1:0]        vid;
        logic [WIN_CNT*FLD_W-1:0] win;
    } cfg_t;
endpackage

// File: rtl/lmr_cfg_regs.sv
module lmr_cfg_regs
    import lmr_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [1:0]               sel,
    input  logic [DATA_W-1:0]        wdata,
    output logic [ADDR_W-1:0]        dram_limit,
    output logic [DATA_W-1:0]        vid_ctl,
    output logic [WIN_CNT*FLD_W-1:0] win_ctl
);
    localparam int HALF = WIN_CNT * FLD_W / 2;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            unique case (sel)
                2'd0: cfg_d.lim = wdata[LIM_LO +: LIM_W];
                2'd1: cfg_d.vid = wdata;
                2'd2: cfg_d.win[HALF-1:0] = wdata[HALF-1:0];
                default: cfg_d.win[2*HALF-1:HALF] = wdata[HALF-1:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.lim <= '1;
            cfg_q.vid <= '0;
            cfg_q.win <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign dram_limit = {{(ADDR_W-LIM_LO-LIM_W){1'b0}}, cfg_q.lim, {LIM_LO{1'b1}}};
    assign vid_ctl    = cfg_q.vid;
    assign win_ctl    = cfg_q.win;
endmodule

// File: rtl/lmr_win_select.sv
module lmr_win_select
    import lmr_pkg::*;
#(
    parameter int CNT = WIN_CNT
) (
    input  logic [CNT*FLD_W-1:0]     ctl,
    input  logic [$clog2(CNT)-1:0]   idx,
    output logic [FLD_W-1:0]         field
);
    logic [FLD_W-1:0] fld_arr [CNT];

    for (genvar g = 0; g < CNT; g++) begin : g_fld
        assign fld_arr[g] = ctl[g*FLD_W +: FLD_W];
    end

    assign field = fld_arr[idx];
endmodule

// File: rtl/lmr_io_trap.sv
module lmr_io_trap
    import lmr_pkg::*;
#(
    parameter int          TRAP_CNT  = 3,
    parameter logic [27:0] FIRST_BLK = 28'h3B
) (
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic [TRAP_CNT-1:0] enable,
    output logic                hit
);
    logic [TRAP_CNT-1:0] blk_hit;

    for (genvar i = 0; i < TRAP_CNT; i++) begin : g_blk
        localparam logic [27:0] BLK = FIRST_BLK + 28'(i);
        assign blk_hit[i] = enable[i] && (io_addr[ADDR_W-1:4] == BLK);
    end

    assign hit = |blk_hit;
endmodule

// File: rtl/legacy_window_router.sv
module legacy_window_router
    import lmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        acc_valid,
    input  logic [31:0] acc_addr,
    input  logic        acc_write,
    input  logic        acc_io,
    input  logic        acc_pci,
    input  logic        acc_smm,
    output logic        rsp_valid,
    output logic [1:0]  rsp_route,
    output logic        rsp_cacheable,
    output logic        rsp_smi,
    output logic [31:0] rsp_addr
);
    localparam int MASK_BIT  = 21;
    localparam int TRAP_LSB  = 13;
    localparam int TRAP_CNT  = 3;
    localparam int IDX_W     = $clog2(WIN_CNT);

    logic [ADDR_W-1:0]        dram_limit;
    logic [DATA_W-1:0]        vid_ctl;
    logic [WIN_CNT*FLD_W-1:0] win_ctl;
    logic [ADDR_W-1:0]        m_addr;
    logic [FLD_W-1:0]         rom_fld, vid_fld, fld;
    logic                     vid_gfx, in_low, in_vid, in_rom, grant, trap_hit;

    resp_t rsp_d, rsp_q;

    lmr_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .sel        (cfg_sel),
        .wdata      (cfg_wdata),
        .dram_limit (dram_limit),
        .vid_ctl    (vid_ctl),
        .win_ctl    (win_ctl)
    );

    always_comb begin
        m_addr = acc_addr;
        if (vid_ctl[MASK_BIT] && !acc_smm) m_addr[20] = 1'b0;
    end

    lmr_win_select #(.CNT(WIN_CNT)) u_win (
        .ctl   (win_ctl),
        .idx   (m_addr[14 +: IDX_W]),
        .field (rom_fld)
    );

    lmr_io_trap #(.TRAP_CNT(TRAP_CNT), .FIRST_BLK(28'h3B)) u_trap (
        .io_addr (m_addr),
        .enable  (vid_ctl[TRAP_LSB +: TRAP_CNT]),
        .hit     (trap_hit)
    );

    always_comb begin
        in_low = (m_addr[ADDR_W-1:20] == '0);
        in_vid = in_low && (m_addr[19:17] == 3'b101);
        in_rom = in_low && (m_addr[19:18] == 2'b11);
        if (!m_addr[16]) begin
            vid_fld = vid_ctl[3:0];
            vid_gfx = vid_ctl[4];
        end else if (!m_addr[15]) begin
            vid_fld = vid_ctl[19:16];
            vid_gfx = vid_ctl[20];
        end else begin
            vid_fld = vid_ctl[27:24];
            vid_gfx = vid_ctl[28];
        end
        fld   = in_vid ? vid_fld : rom_fld;
        grant = acc_write ? fld[1] : fld[0];
    end

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = acc_valid;
        if (acc_valid) begin
            rsp_d.addr      = m_addr;
            rsp_d.smi       = 1'b0;
            rsp_d.cacheable = 1'b0;
            if (acc_io) begin
                rsp_d.route = ROUTE_PCI;
                rsp_d.smi   = trap_hit;
            end else if (in_vid && vid_gfx) begin
                rsp_d.route = ROUTE_GFX;
            end else if (in_vid || in_rom) begin
                if (acc_pci) begin
                    rsp_d.route = (fld[3] && grant) ? ROUTE_DRAM : ROUTE_DENY;
                end else begin
                    rsp_d.route     = grant ? ROUTE_DRAM : ROUTE_PCI;
                    rsp_d.cacheable = fld[2];
                end
            end else if (in_low || (m_addr <= dram_limit)) begin
                rsp_d.route     = ROUTE_DRAM;
                rsp_d.cacheable = !acc_pci;
            end else begin
                rsp_d.route = acc_pci ? ROUTE_DENY : ROUTE_PCI;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid     = rsp_q.valid;
    assign rsp_route     = rsp_q.route;
    assign rsp_cacheable = rsp_q.cacheable;
    assign rsp_smi       = rsp_q.smi;
    assign rsp_addr      = rsp_q.addr;

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);

    assert_gfx_uncached_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_route == ROUTE_GFX) |-> !rsp_cacheable);

    assert_io_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_io) |=> (rsp_route == ROUTE_PCI) && !rsp_cacheable);

    assert_smi_from_io_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_smi) |-> $past(acc_io));

    assert_slave_uncached_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_pci) |=> !rsp_cacheable);

    assert_deny_slave_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_route == ROUTE_DENY) |-> $past(acc_pci));

    assert_a20_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && vid_ctl[MASK_BIT] && !acc_smm) |=> !rsp_addr[20]);
endmodule

// File: tb/legacy_window_router_tb.sv
module legacy_window_router_tb;
    localparam logic [1:0] DRAM = 2'd0, GFX = 2'd1, PCI = 2'd2, DENY = 2'd3;

    typedef struct {
        logic [1:0]  route;
        logic        cach;
        logic        smi;
        logic [31:0] addr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0, acc_io = 1'b0, acc_pci = 1'b0, acc_smm = 1'b0;
    logic        rsp_valid, rsp_cacheable, rsp_smi;
    logic [1:0]  rsp_route;
    logic [31:0] rsp_addr;

    int   n_chk = 0;
    int   n_err = 0;
    exp_t expq[$];

    always #5 clk = ~clk;

    legacy_window_router u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
        .acc_io(acc_io), .acc_pci(acc_pci), .acc_smm(acc_smm),
        .rsp_valid(rsp_valid), .rsp_route(rsp_route), .rsp_cacheable(rsp_cacheable),
        .rsp_smi(rsp_smi), .rsp_addr(rsp_addr)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // monitor: results are due one clock after the access
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_chk++;
            if (expq.size() == 0) begin
                n_err++;
                $display("FAIL R2 unexpected result: got valid=1 expected valid=0");
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (rsp_route !== e.route || rsp_cacheable !== e.cach ||
                    rsp_smi !== e.smi || rsp_addr !== e.addr) begin
                    n_err++;
                    $display("FAIL %s: got route=%0d c=%0b smi=%0b addr=%h expected route=%0d c=%0b smi=%0b addr=%h",
                             e.tag, rsp_route, rsp_cacheable, rsp_smi, rsp_addr,
                             e.route, e.cach, e.smi, e.addr);
                end
            end
        end
    end

    task automatic drive(input logic [31:0] a, input bit wr, io, pci, smm,
                         input logic [1:0] er, input bit ec, es,
                         input logic [31:0] ea, input string tag);
        exp_t e;
        acc_valid = 1'b1; acc_addr = a; acc_write = wr;
        acc_io = io; acc_pci = pci; acc_smm = smm;
        e.route = er; e.cach = ec; e.smi = es; e.addr = ea; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic acc(input logic [31:0] a, input bit wr, io, pci, smm,
                       input logic [1:0] er, input bit ec, es, input string tag);
        @(negedge clk);
        drive(a, wr, io, pci, smm, er, ec, es, a, tag);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic wreg(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired: got running expected finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (rsp_valid !== 1'b0 || rsp_route !== 2'd0 || rsp_cacheable !== 1'b0 ||
            rsp_smi !== 1'b0 || rsp_addr !== 32'h0) begin
            n_err++;
            $display("FAIL R1 reset outputs: got v=%b r=%0d c=%b s=%b a=%h expected all 0",
                     rsp_valid, rsp_route, rsp_cacheable, rsp_smi, rsp_addr);
        end
        // R1 defaults
        acc(32'h000C_0000, 0, 0, 0, 0, PCI,  0, 0, "R1 rom default");
        acc(32'h0020_0000, 0, 0, 0, 0, DRAM, 1, 0, "R1 limit default");
        // R3 low memory
        acc(32'h0001_2345, 0, 0, 0, 0, DRAM, 1, 0, "R3 low read");
        acc(32'h0009_FFFF, 1, 0, 0, 0, DRAM, 1, 0, "R3 low write edge");
        // R4 R5 R6 R7 window fields
        wreg(2'd2, 32'hB000_0957);
        wreg(2'd3, 32'h4000_0001);
        acc(32'h000C_0000, 0, 0, 0, 0, DRAM, 1, 0, "R4 R5 win0 read");
        acc(32'h000C_3FFF, 0, 0, 0, 0, DRAM, 1, 0, "R4 win0 top edge");
        acc(32'h000C_0010, 1, 0, 0, 0, DRAM, 1, 0, "R5 win0 write");
        acc(32'h000C_4000, 0, 0, 0, 0, DRAM, 1, 0, "R4 win1 read");
        acc(32'h000C_4000, 1, 0, 0, 0, PCI,  1, 0, "R6 win1 write not writable cached");
        acc(32'h000D_C000, 0, 0, 0, 0, DRAM, 0, 0, "R6 win7 uncached read");
        acc(32'h000D_C000, 0, 0, 1, 0, DRAM, 0, 0, "R7 slave read allowed");
        acc(32'h000D_C004, 1, 0, 1, 0, DRAM, 0, 0, "R7 slave write allowed");
        acc(32'h000C_0000, 0, 0, 1, 0, DENY, 0, 0, "R7 slave no access bit");
        acc(32'h000C_8000, 1, 0, 1, 0, DENY, 0, 0, "R7 slave write not enabled");
        acc(32'h000C_8000, 0, 0, 1, 0, DRAM, 0, 0, "R7 slave read enabled");
        acc(32'h000E_0000, 0, 0, 0, 0, DRAM, 0, 0, "R4 win8 read");
        acc(32'h000E_0000, 1, 0, 0, 0, PCI,  0, 0, "R5 win8 write");
        acc(32'h000F_C000, 0, 0, 0, 0, PCI,  1, 0, "R6 win15 cached no read");
        acc(32'h000F_FFFF, 0, 0, 0, 0, PCI,  1, 0, "R4 win15 last byte");
        acc(32'h000F_8000, 0, 0, 0, 0, PCI,  0, 0, "R4 win14 zero field");
        // R8 video windows
        wreg(2'd1, 32'h1007_0013);
        acc(32'h000A_0000, 0, 0, 0, 0, GFX,  0, 0, "R8 A gfx");
        acc(32'h000A_FFFF, 1, 0, 0, 0, GFX,  0, 0, "R8 A gfx edge");
        acc(32'h000B_0000, 0, 0, 0, 0, DRAM, 1, 0, "R8 B0 field");
        acc(32'h000B_7FFF, 1, 0, 0, 0, DRAM, 1, 0, "R8 B0 write edge");
        acc(32'h000B_8000, 0, 0, 0, 0, GFX,  0, 0, "R8 B8 gfx");
        acc(32'h000B_FFFF, 1, 0, 0, 0, GFX,  0, 0, "R8 B8 gfx edge");
        // R9 R10 traps and mask
        wreg(2'd1, 32'h1027_A003);
        acc(32'h000A_0000, 0, 0, 0, 0, DRAM, 0, 0, "R8 A field no gfx");
        acc(32'h0000_03B0, 0, 1, 0, 0, PCI,  0, 1, "R9 trap 3B0");
        acc(32'h0000_03BF, 1, 1, 0, 0, PCI,  0, 1, "R9 trap 3BF");
        acc(32'h0000_03C0, 0, 1, 0, 0, PCI,  0, 0, "R9 3C0 disabled");
        acc(32'h0000_03DF, 0, 1, 0, 0, PCI,  0, 1, "R9 trap 3DF");
        acc(32'h0000_03E0, 0, 1, 0, 0, PCI,  0, 0, "R9 3E0 outside");
        acc(32'h0000_03AF, 0, 1, 0, 0, PCI,  0, 0, "R9 3AF outside");
        acc(32'h0000_03B0, 0, 0, 0, 0, DRAM, 1, 0, "R9 memory no trap");
        @(negedge clk);
        drive(32'h001A_0000, 0, 0, 0, 0, DRAM, 0, 0, 32'h000A_0000, "R10 masked");
        @(negedge clk);
        drive(32'h001A_0000, 0, 0, 0, 1, DRAM, 1, 0, 32'h001A_0000, "R10 smm unmasked");
        @(negedge clk);
        drive(32'h0030_0000, 0, 0, 0, 0, DRAM, 1, 0, 32'h0020_0000, "R10 masked high");
        @(negedge clk);
        acc_valid = 1'b0;
        // R11 DRAM limit
        wreg(2'd1, 32'h1007_A003);
        wreg(2'd0, 32'hFFFF_FFFF);
        acc(32'h3FFF_FFFF, 0, 0, 0, 0, DRAM, 1, 0, "R11 ignored high bits limit");
        acc(32'h4000_0000, 0, 0, 0, 0, PCI,  0, 0, "R11 above max limit");
        wreg(2'd0, 32'h0020_0000);
        acc(32'h0021_FFFF, 0, 0, 0, 0, DRAM, 1, 0, "R11 at limit");
        acc(32'h0022_0000, 0, 0, 0, 0, PCI,  0, 0, "R11 above limit");
        acc(32'h0022_0000, 0, 0, 1, 0, DENY, 0, 0, "R11 slave above limit");
        acc(32'h0010_0000, 0, 0, 1, 0, DRAM, 0, 0, "R11 slave below limit");
        // R12 same-cycle write uses old value
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'h0;
        drive(32'h000C_0000, 0, 0, 0, 0, DRAM, 1, 0, 32'h000C_0000, "R12 old value");
        @(negedge clk);
        cfg_we = 1'b0;
        drive(32'h000C_0000, 0, 0, 0, 0, PCI, 0, 0, 32'h000C_0000, "R12 new value");
        @(negedge clk);
        acc_valid = 1'b0;
        repeat (4) @(negedge clk);
        n_chk++;
        if (expq.size() != 0) begin
            n_err++;
            $display("FAIL R2 missing results: got %0d pending expected 0", expq.size());
        end
        summary();
    end
endmodule